// File: doc/BRIEF.md
# Bidirectional Turbine Pulse Volume Counter

This block sits behind the two optical pickups of a rotating-vane flow turbine. The pickups give two square waves a quarter cycle apart. Which one leads depends on which way air moves through the turbine. The block cleans up both waveforms, decodes them as a four-state quadrature sequence, and keeps a signed step count. That count is the raw volume in turbine steps. It also times the spacing between successive rising edges of the first pickup. Flow is inversely proportional to that spacing.

Software, or a downstream block, scales the count to litres and divides to get flow. This block supplies only the raw count, the latest period in clock cycles, the direction seen at that edge, and a strobe that marks each new period value. A gate input turns measurement on for the length of a blow. A synchronous clear starts a new measurement.

Top module: `vane_pulse_counter`

## Requirements
- R1: When reset or clear is active, the next clock edge sets the count to 0, the period to 0 and the error flag to 0, and the strobe stays low.
- R2: The pickup pair is taken as the code {A,B}. While the gate is high, each filtered transition in the forward order 00, 10, 11, 01, 00 (A leads B) adds 1 to the signed two's-complement count.
- R3: While the gate is high, each filtered transition in the reverse order 00, 01, 11, 10, 00 subtracts 1 from the count.
- R4: If A and B change in the same filtered cycle, the count does not change and the error flag sets. The flag stays set until a clear or a reset.
- R5: Each pickup passes through a two-flop synchroniser and then a three-sample majority filter. A raw pulse lasting one clock cycle is ignored. A level held for two or more cycles is passed on.
- R6: The period output holds the number of clock cycles between two successive filtered rising edges of A. It is loaded together with a one-cycle strobe. The first rising edge after reset, clear or gate opening only arms the timer, and it produces no strobe.
- R7: On the strobe cycle, the direction output is 1 if B was low at the rising edge of A (forward flow). It is 0 if B was high (reverse flow).
- R8: The period timer saturates at 2^PER_W-1. Once it reaches that value, the period output reads 0, meaning stall, with no strobe. The next rising edge loads a period of 0.
- R9: While the gate is low, the count and error flag hold and no strobe occurs. The decoder keeps tracking the inputs, so reopening the gate causes no spurious step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of count, period and error |
| gate_i | input | 1 | Measurement enable |
| pick_a_i | input | 1 | Pickup A, asynchronous |
| pick_b_i | input | 1 | Pickup B, asynchronous |
| count_o | output | CNT_W | Signed step count (volume) |
| period_o | output | PER_W | Last A-to-A period in cycles, 0 for stall |
| dir_o | output | 1 | Direction at the last strobe, 1 = forward |
| strobe_o | output | 1 | One-cycle mark of a newly loaded period |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Direction reversal partway through the run.** A decoder with its step table inverted, or with a wrong direction sense, would count the wrong way.
- **A one-cycle glitch on a pickup.** A missing majority filter would turn the glitch into an extra step.
- **A same-cycle double change.** A decoder that treats this as a step would move the count, or would fail to raise the sticky flag.
- **Steps taken with the gate low, then the gate reopened.** A design that kept counting, or that lost track of the pickup state, would shift the count.
- **A stall longer than the timer range.** A design without saturation would wrap and report a bogus period instead of 0.
- **The first edge after clear or gate opening.** A design missing the arming rule would emit a strobe with a meaningless period.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Forward successor of a {A,B} code.
  function automatic logic [1:0] fwd_succ(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // Classify a move between two consecutive filtered codes.
  function automatic step_e quad_step(input logic [1:0] prv, input logic [1:0] cur);
    if (prv == cur)                 return STEP_NONE;
    else if ((prv ^ cur) == 2'b11)  return STEP_BAD;
    else if (cur == fwd_succ(prv))  return STEP_UP;
    else                            return STEP_DOWN;
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/vpc_input_filter.sv
module vpc_input_filter #(
  parameter int CH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CH-1:0] raw_i,
  output logic [CH-1:0] filt_o
);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [1:0] meta_q;
    logic [1:0] hist_q;
    logic       filt_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        meta_q <= '0;
        hist_q <= '0;
        filt_q <= 1'b0;
      end else begin
        meta_q <= {meta_q[0], raw_i[g]};
        hist_q <= {hist_q[0], meta_q[1]};
        filt_q <= vpc_pkg::maj3(meta_q[1], hist_q[0], hist_q[1]);
      end
    end

    assign filt_o[g] = filt_q;
  end

endmodule

// File: rtl/vpc_quad_decoder.sv
module vpc_quad_decoder (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          ab_i,
  output vpc_pkg::step_e      step_o,
  output logic                a_rise_o,
  output logic                b_lvl_o
);

  logic [1:0] prev_q;

  // Tracks the inputs regardless of gate so no false step on reopen.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= ab_i;
  end

  assign step_o   = vpc_pkg::quad_step(prev_q, ab_i);
  assign a_rise_o = ab_i[1] & ~prev_q[1];
  assign b_lvl_o  = ab_i[0];

endmodule

// File: rtl/vpc_period_timer.sv
module vpc_period_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             gate_i,
  input  logic             a_rise_i,
  input  logic             b_lvl_i,
  output logic [PER_W-1:0] period_o,
  output logic             strobe_o,
  output logic             dir_o
);

  localparam logic [PER_W-1:0] TMAX = {PER_W{1'b1}};

  logic [PER_W-1:0] tmr_q;
  logic             armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      tmr_q    <= '0;
      armed_q  <= 1'b0;
      period_o <= '0;
      strobe_o <= 1'b0;
      dir_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (!gate_i) begin
        armed_q <= 1'b0;
      end else if (a_rise_i) begin
        tmr_q   <= PER_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          strobe_o <= 1'b1;
          period_o <= (tmr_q == TMAX) ? '0 : tmr_q;
          dir_o    <= ~b_lvl_i;
        end
      end else if (armed_q) begin
        if (tmr_q != TMAX) tmr_q <= tmr_q + PER_W'(1);
        else               period_o <= '0;
      end
    end
  end

endmodule

// File: rtl/vane_pulse_counter.sv
module vane_pulse_counter #(
  parameter int CNT_W = 16,
  parameter int PER_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    gate_i,
  input  logic                    pick_a_i,
  input  logic                    pick_b_i,
  output logic signed [CNT_W-1:0] count_o,
  output logic [PER_W-1:0]        period_o,
  output logic                    dir_o,
  output logic                    strobe_o,
  output logic                    err_o
);

  import vpc_pkg::*;

  logic [1:0] filt_ab;
  step_e      step_w;
  logic       a_rise_w;
  logic       b_lvl_w;
  logic       ill_ev;

  function automatic logic signed [CNT_W-1:0] next_count(
    input logic signed [CNT_W-1:0] c, input step_e s);
    case (s)
      STEP_UP:   return c + CNT_W'(1);
      STEP_DOWN: return c - CNT_W'(1);
      default:   return c;
    endcase
  endfunction

  vpc_input_filter #(.CH(2)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({pick_a_i, pick_b_i}),
    .filt_o (filt_ab)
  );

  vpc_quad_decoder u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ab_i     (filt_ab),
    .step_o   (step_w),
    .a_rise_o (a_rise_w),
    .b_lvl_o  (b_lvl_w)
  );

  vpc_period_timer #(.PER_W(PER_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .gate_i   (gate_i),
    .a_rise_i (a_rise_w),
    .b_lvl_i  (b_lvl_w),
    .period_o (period_o),
    .strobe_o (strobe_o),
    .dir_o    (dir_o)
  );

  assign ill_ev = gate_i && (step_w == STEP_BAD);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      count_o <= '0;
      err_o   <= 1'b0;
    end else if (gate_i) begin
      count_o <= next_count(count_o, step_w);
      if (ill_ev) err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int CNT_W = 16,
  parameter int PER_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             gate_i,
  input logic [CNT_W-1:0] count_o,
  input logic [PER_W-1:0] period_o,
  input logic             strobe_o,
  input logic             err_o,
  input logic             ill_ev
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] NEG1 = {CNT_W{1'b1}};

  // R2 R3
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> ((count_o - $past(count_o)) == '0 ||
                         (count_o - $past(count_o)) == ONE ||
                         (count_o - $past(count_o)) == NEG1));

  // R1
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && period_o == '0 && !err_o && !strobe_o));

  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clear_i |=> err_o);

  // R4
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_ev && !clear_i |=> err_o && $stable(count_o));

  // R9
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i && !clear_i |=> $stable(count_o) && $stable(err_o));

  // R9
  strobe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(gate_i));

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

endmodule

bind vane_pulse_counter vpc_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .gate_i   (gate_i),
  .count_o  (count_o),
  .period_o (period_o),
  .strobe_o (strobe_o),
  .err_o    (err_o),
  .ill_ev   (ill_ev)
);

// File: tb/vane_pulse_counter_bench.sv
module vane_pulse_counter_bench;

  localparam int CNT_W = 16;
  localparam int PER_W = 12;
  localparam int TSAT  = (1 << PER_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic gate = 1'b0;
  logic raw_a = 1'b0;
  logic raw_b = 1'b0;
  logic signed [CNT_W-1:0] count;
  logic [PER_W-1:0] period;
  logic dir, strobe, err;

  always #10 clk = ~clk;

  vane_pulse_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_vane_pulse_counter (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .gate_i(gate),
    .pick_a_i(raw_a), .pick_b_i(raw_b),
    .count_o(count), .period_o(period), .dir_o(dir),
    .strobe_o(strobe), .err_o(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt[$];
  int exp_per[$];
  bit exp_dir[$];
  int cyc = 0;
  int last_rise = 0;
  bit armed = 0;
  logic [1:0] st = 2'b00;
  int model_cnt = 0;
  int last_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [1:0] f_next(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] r_next(input logic [1:0] s);
    case (s)
      2'b10: return 2'b00;
      2'b11: return 2'b10;
      2'b01: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    cyc += n;
  endtask

  // Drive a new {A,B} code; model the period strobe (R6, R7, R8).
  task automatic apply(input logic [1:0] nx);
    if (gate && !st[1] && nx[1]) begin
      if (armed) begin
        exp_per.push_back((cyc - last_rise) >= TSAT ? 0 : (cyc - last_rise));
        exp_dir.push_back(~nx[0]);
      end
      armed = 1;
      last_rise = cyc;
    end
    raw_a = nx[1];
    raw_b = nx[0];
    st = nx;
  endtask

  task automatic step(input bit fwd, input int hold);
    if (gate) begin
      model_cnt += fwd ? 1 : -1;
      exp_cnt.push_back(model_cnt);
    end
    apply(fwd ? f_next(st) : r_next(st));
    idle(hold);
  endtask

  // Monitor: scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(count) != last_seen) begin
        if (exp_cnt.size() == 0) chk(0, "R2/R3/R9 unexpected count change", int'(count), last_seen);
        else begin
          int e;
          e = exp_cnt.pop_front();
          chk(int'(count) == e, "R2/R3 count", int'(count), e);
        end
        last_seen = int'(count);
      end
      if (strobe) begin
        if (exp_per.size() == 0) chk(0, "R6 unexpected strobe", int'(period), -1);
        else begin
          int p;
          bit d;
          p = exp_per.pop_front();
          d = exp_dir.pop_front();
          chk(int'(period) == p, "R6/R8 period", int'(period), p);
          chk(dir == d, "R7 direction", int'(dir), int'(d));
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(count == 0, "R1 reset count", int'(count), 0);
    chk(period == 0, "R1 reset period", int'(period), 0);
    chk(!strobe && !err, "R1 reset strobe/err", int'({strobe, err}), 0);

    gate = 1'b1;
    idle(8);
    // R2 forward, steady rate
    for (int i = 0; i < 12; i++) step(1, 5);
    idle(10);
    chk(int'(count) == 12, "R2 forward total", int'(count), 12);

    // R3 reverse
    for (int i = 0; i < 8; i++) step(0, 4);
    idle(10);
    chk(int'(count) == 4, "R3 reverse total", int'(count), 4);

    // R6 varying rate
    for (int i = 0; i < 8; i++) step(1, 3 + 2 * i);
    idle(10);

    // R5 one-cycle glitch on A
    raw_a = ~raw_a;
    idle(1);
    raw_a = ~raw_a;
    idle(12);
    chk(int'(count) == model_cnt, "R5 glitch ignored", int'(count), model_cnt);

    // R4 illegal double change
    apply(st ^ 2'b11);
    idle(10);
    chk(err == 1'b1, "R4 error flag", int'(err), 1);
    chk(int'(count) == model_cnt, "R4 count held", int'(count), model_cnt);
    for (int i = 0; i < 4; i++) step(1, 5);
    idle(8);
    chk(err == 1'b1, "R4 error sticky", int'(err), 1);

    // R9 gate low
    gate = 1'b0;
    armed = 0;
    idle(8);
    for (int i = 0; i < 6; i++) step(1, 5);
    idle(8);
    chk(int'(count) == model_cnt, "R9 gated count held", int'(count), model_cnt);
    gate = 1'b1;
    idle(8);
    for (int i = 0; i < 8; i++) step(1, 6);
    idle(10);
    chk(int'(count) == model_cnt, "R9 resume no jump", int'(count), model_cnt);

    // R8 stall
    idle(TSAT + 100);
    chk(period == 0, "R8 stall period zero", int'(period), 0);
    for (int i = 0; i < 4; i++) step(1, 5);
    idle(10);

    // R1 clear
    if (model_cnt != 0) begin
      model_cnt = 0;
      exp_cnt.push_back(0);
    end
    clear = 1'b1;
    idle(1);
    clear = 1'b0;
    armed = 0;
    idle(3);
    chk(count == 0, "R1 clear count", int'(count), 0);
    chk(period == 0, "R1 clear period", int'(period), 0);
    chk(err == 0, "R1 clear err", int'(err), 0);

    // R6 arming after clear
    for (int i = 0; i < 8; i++) step(1, 4);
    idle(20);

    chk(exp_cnt.size() == 0, "R2 all count steps seen", exp_cnt.size(), 0);
    chk(exp_per.size() == 0, "R6 all strobes seen", exp_per.size(), 0);
    finish_run();
  end

endmodule